// File: doc/BRIEF.md
# Rotate and Mask Generator

This block prepares the two operands that bit-field and shift operations need: a data word turned left by a chosen number of bit positions, and a mask of contiguous ones. The rotation amount is a 4-bit value, and a 16-bit word is rotated left by that many places. The mask is built in parallel from a 4-bit width code. It is flush with either the low end or the high end of the word, as a justify input selects.

A flag marks a shift count whose magnitude exceeds the word width. When that flag is set, the rotation is abandoned, the data result is zero, and an indicator on the output reports the case. Operands enter through a valid/ready handshake. Each result is registered and appears one cycle after its operands are accepted. A result that is not yet taken holds the input stage closed, so it is never overwritten.

Top module: `rot_mask_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and `op_ready` is 1.
- R2: With `op_range_err` low, `res_data` equals `op_data` rotated left by `op_rot` positions (0 = unchanged, k = bits move up k places and wrap), and `res_range_err` is 0.
- R3: With `op_justify` = 0, the width code c (0..15) gives a mask of c+1 ones starting at bit 0: code 0 gives 0x0001, code 7 gives 0x00FF, code 15 gives 0xFFFF.
- R4: With `op_justify` = 1, the width code n gives n ones ending at bit 15, and code 0 means sixteen ones: code 1 gives 0x8000, code 4 gives 0xF000, code 0 gives 0xFFFF.
- R5: With `op_range_err` high, `res_data` is 0 and `res_range_err` is 1, and the mask still follows R3 or R4.
- R6: Operands are accepted on a rising edge where `op_valid` and `op_ready` are both 1. The matching result is shown with `res_valid` = 1 from the next cycle onward.
- R7: While `res_valid` is 1 and `res_ready` is 0, every result output keeps its value and `op_ready` is 0. An operand offered during that time is not taken until the result has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operands present |
| op_ready | output | 1 | Block can accept operands |
| op_data | input | 16 | Word to rotate |
| op_rot | input | 4 | Left rotation amount |
| op_width | input | 4 | Mask width code |
| op_justify | input | 1 | 0 = mask at low end, 1 = mask at high end |
| op_range_err | input | 1 | Shift count out of range; abandon rotation |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Rotated word, or 0 on a range error |
| res_mask | output | 16 | Generated mask |
| res_range_err | output | 1 | Result came from an out-of-range shift |

## Verification
Rotation is checked over every amount, including 0 and 15, with walking-one words and random words. A walking one shows the exact bit displacement. Random words expose wrong wrap-around of the high bits. Both mask modes are checked over all sixteen codes and at the end points 0, 1 and 15, which separates a code-plus-one off-by-one error from a mis-justified mask. Out-of-range operands are mixed into the random stream to show that only the data is zeroed. Stalls with an operand waiting show whether the handshake loses or replaces a result.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
    localparam int WORD_W = 16;
    localparam int AMT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] mask;
        logic              range_err;
    } rm_stage_t;
endpackage

// File: rtl/rm_rotator.sv
// Left rotate in two steps: a coarse rotate by a multiple of a quarter word,
// then a small fine step of -1, 0, +1 or +2 places.
module rm_rotator #(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    localparam int Q = W / 4;

    logic [1:0]    coarse_sel;
    logic [SW-1:0] coarse_amt;
    logic [SW-1:0] fine_amt;
    logic [W-1:0]  coarse_opt [4];
    logic [W-1:0]  coarse_out;
    logic [W-1:0]  fine_opt [4];

    always_comb begin
        coarse_sel = 2'((32'(amt) + 1) / Q);
        coarse_amt = SW'(32'(coarse_sel) * Q);
        fine_amt   = amt - coarse_amt;
    end

    for (genvar g = 0; g < 4; g++) begin : g_coarse
        if (g == 0) begin : g_zero
            assign coarse_opt[g] = din;
        end else begin : g_rot
            assign coarse_opt[g] = {din[W-1-g*Q:0], din[W-1:W-g*Q]};
        end
    end

    assign coarse_out = coarse_opt[coarse_sel];

    assign fine_opt[0] = coarse_out;
    assign fine_opt[1] = {coarse_out[W-2:0], coarse_out[W-1]};
    assign fine_opt[2] = {coarse_out[W-3:0], coarse_out[W-1:W-2]};
    assign fine_opt[3] = {coarse_out[0], coarse_out[W-1:1]};

    always_comb begin
        case (fine_amt)
            SW'(0):   dout = fine_opt[0];
            SW'(1):   dout = fine_opt[1];
            SW'(2):   dout = fine_opt[2];
            default:  dout = fine_opt[3];
        endcase
    end

    // Rotation never creates or loses a set bit.
    always_comb begin
        a_r2_rot_keeps_ones: assert ($countones(dout) == $countones(din));
    end
endmodule

// File: rtl/rm_mask_gen.sv
// Mask of contiguous ones. Low-end mode: code c gives c+1 ones.
// High-end mode: low-end mask for code (0 - n), inverted, shifted right with a 1 in.
module rm_mask_gen #(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input  logic [SW-1:0] code,
    input  logic          high_end,
    output logic [W-1:0]  mask
);
    logic [SW-1:0] eff_code;
    logic [W-1:0]  low_mask;

    assign eff_code = high_end ? (SW'(0) - code) : code;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign low_mask[i] = (SW'(i) <= eff_code);
    end

    assign mask = high_end ? {1'b1, ~low_mask[W-1:1]} : low_mask;

    always_comb begin
        a_r3_low_anchor: assert (high_end || mask[0]);
        a_r4_high_anchor: assert (!high_end || mask[W-1]);
    end
endmodule

// File: rtl/rot_mask_unit.sv
module rot_mask_unit
    import rotmask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [WORD_W-1:0] op_data,
    input  logic [AMT_W-1:0]  op_rot,
    input  logic [AMT_W-1:0]  op_width,
    input  logic              op_justify,
    input  logic              op_range_err,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [WORD_W-1:0] res_data,
    output logic [WORD_W-1:0] res_mask,
    output logic              res_range_err
);
    rm_stage_t     st_d, st_q;
    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] mask_w;
    logic              take;

    rm_rotator #(.W(WORD_W), .SW(AMT_W)) u_rot (
        .din  (op_data),
        .amt  (op_rot),
        .dout (rot_w)
    );

    rm_mask_gen #(.W(WORD_W), .SW(AMT_W)) u_mask (
        .code     (op_width),
        .high_end (op_justify),
        .mask     (mask_w)
    );

    assign op_ready = !st_q.valid || res_ready;
    assign take     = op_valid && op_ready;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.valid     = 1'b1;
            st_d.data      = op_range_err ? '0 : rot_w;
            st_d.mask      = mask_w;
            st_d.range_err = op_range_err;
        end else if (res_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid     = st_q.valid;
    assign res_data      = st_q.data;
    assign res_mask      = st_q.mask;
    assign res_range_err = st_q.range_err;

    a_r6_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> res_valid);

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)
                                       && $stable(res_mask) && $stable(res_range_err)));

    a_r7_closed_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !op_ready);

    a_r5_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_range_err) |-> (res_data == '0));

    a_r3_low_count: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !op_justify) |=> ($countones(res_mask) == $past(32'(op_width)) + 1));
endmodule

// File: tb/rot_mask_unit_test.sv
module rot_mask_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [15:0] op_data = '0;
    logic [3:0]  op_rot = '0;
    logic [3:0]  op_width = '0;
    logic        op_justify = 1'b0;
    logic        op_range_err = 1'b0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [15:0] res_data;
    logic [15:0] res_mask;
    logic        res_range_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rot_mask_unit uut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready),
        .op_data(op_data), .op_rot(op_rot), .op_width(op_width),
        .op_justify(op_justify), .op_range_err(op_range_err),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_mask(res_mask), .res_range_err(res_range_err)
    );

    function automatic logic [15:0] exp_rot(logic [15:0] d, int k);
        logic [31:0] w = {d, d};
        return w[31-k -: 16];
    endfunction

    function automatic logic [15:0] exp_mask(int code, logic hi);
        logic [16:0] t;
        if (!hi) begin
            t = (17'd1 << (code + 1)) - 17'd1;
            return t[15:0];
        end
        if (code == 0) return 16'hFFFF;
        t = (17'd1 << (16 - code)) - 17'd1;
        return ~t[15:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [15:0] d, int k, int c, logic hi, logic err);
        @(negedge clk);
        op_valid = 1'b1; op_data = d; op_rot = 4'(k); op_width = 4'(c);
        op_justify = hi; op_range_err = err; res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R6 valid", 32'(res_valid), 32'd1);
        chk(err ? "R5 data" : "R2 data", 32'(res_data), err ? 32'd0 : 32'(exp_rot(d, k)));
        chk(hi ? "R4 mask" : "R3 mask", 32'(res_mask), 32'(exp_mask(c, hi)));
        chk("R5 flag", 32'(res_range_err), 32'(err));
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid", 32'(res_valid), 32'd0);
        chk("R1 ready", 32'(op_ready), 32'd1);
        rst_n = 1'b1;

        for (int k = 0; k < 16; k++) run_op(16'h0001, k, k, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) run_op(16'h8421 ^ 16'(k), k, k, 1'b1, 1'b0);
        run_op(16'hABCD, 0, 0, 1'b0, 1'b0);  // R3 code 0
        run_op(16'hABCD, 15, 7, 1'b0, 1'b0); // R3 code 7
        run_op(16'hABCD, 1, 15, 1'b0, 1'b0); // R3 code 15
        run_op(16'h1234, 4, 1, 1'b1, 1'b0);  // R4 one bit at top
        run_op(16'h1234, 8, 4, 1'b1, 1'b0);  // R4 four bits
        run_op(16'h1234, 3, 0, 1'b1, 1'b0);  // R4 zero means sixteen
        run_op(16'hFFFF, 5, 3, 1'b0, 1'b1);  // R5 range error
        run_op(16'hFFFF, 9, 2, 1'b1, 1'b1);  // R5 range error, high mask

        for (int i = 0; i < 300; i++) begin
            run_op(16'($urandom), int'($urandom % 16), int'($urandom % 16),
                   1'($urandom), ($urandom % 8) == 0);
        end

        // R7: stall with a second operand waiting
        @(negedge clk);
        op_valid = 1'b1; op_data = 16'h00F1; op_rot = 4'd4; op_width = 4'd2;
        op_justify = 1'b0; op_range_err = 1'b0; res_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        op_data = 16'h0F00; op_rot = 4'd1; op_width = 4'd5; op_justify = 1'b1;
        chk("R7 ready low", 32'(op_ready), 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 held data", 32'(res_data), 32'h0F10);
        chk("R7 held mask", 32'(res_mask), 32'h0007);
        chk("R7 still valid", 32'(res_valid), 32'd1);
        res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 next data", 32'(res_data), 32'h1E00);
        chk("R7 next mask", 32'(res_mask), 32'hF800);
        @(posedge clk);
        @(negedge clk);
        chk("R6 drained", 32'(res_valid), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule